// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of payload bytes into a bit-synchronous HDLC line signal. It takes bytes over a valid/ready handshake, with a marker on the final byte of each frame. On the serial output it sends an opening flag, then the payload, then a 16-bit frame check sequence computed while the payload goes out, then a closing flag. It inserts a zero after every run of five ones in the payload and FCS, so the flag pattern cannot appear inside a frame.

The output moves by one bit only on a bit-enable tick, so the line rate is set by whoever drives the tick and not by the clock. When no frame is pending, the line carries back-to-back flags. The framer does not support a payload source that runs dry in the middle of a frame. In that case it drops the frame, raises an error pulse and goes back to sending flags.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, `tx_bit` is 1, and `in_ready` and `underrun_err` are both 0.
- R2: While no frame is in progress, the line carries back-to-back flags. A flag is the byte 0x7E sent LSB first, which is the bit sequence 0,1,1,1,1,1,1,0.
- R3: A frame on the line is an opening flag, then every payload byte in the order accepted, then two FCS bytes, then a closing flag. The flags are never stuffed.
- R4: Every payload and FCS byte is sent LSB first, so 0x11 appears on the line as 1,0,0,0,1,0,0,0.
- R5: The FCS is the CRC with polynomial x^16+x^12+x^5+1, processed bit-reflected. The register is preset to 0xFFFF and the result is inverted. It is sent low byte first. For the ASCII payload "123456789" the sent FCS value is 0x906E.
- R6: After five consecutive ones from payload or FCS bits, one 0 bit is inserted. The count of ones carries across byte boundaries, including from payload into FCS and from FCS to the closing flag. No line run of ones is longer than six.
- R7: `tx_bit` changes only in the clock cycle after a cycle in which `bit_en` was high. Each tick either emits one frame bit or emits one inserted zero.
- R8: `in_ready` is high only in a cycle that has both `bit_en` and `in_valid`, at a byte boundary where the framer takes a payload byte. A byte is accepted when `in_valid` and `in_ready` are both high.
- R9: If the framer needs the next payload byte while `in_valid` is low, it drops the frame. `underrun_err` goes high for exactly one clock and flags resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line-rate tick; one output bit per tick |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is present |
| in_last | input | 1 | Marks the final payload byte of a frame |
| in_ready | output | 1 | Byte is taken this cycle |
| tx_bit | output | 1 | Serial line bit |
| underrun_err | output | 1 | One-clock pulse on payload underrun |

## Verification
The bench builds the framer with its default settings: a five-ones stuffing limit, flag 0x7E, and the reflected CCITT polynomial with an all-ones preset. With these values, a sweep over all 256 one-byte frames can be compared bit for bit against a reference stream. The bench computes that reference with a non-reflected CRC run over bit-reversed bytes. Further frames of all-ones bytes, of zero bytes and of flag-valued bytes, together with tick spacings of one, two and three clocks, bring stuffing across byte and FCS boundaries within reach. So do held output between ticks and the underrun drop.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    SEG_FLAG,
    SEG_DATA,
    SEG_FCS_LO,
    SEG_FCS_HI
  } seg_e;

  // One bit of a reflected CRC: shift right, fold polynomial on feedback.
  function automatic logic [FCS_W-1:0] fcs_step(
    input logic [FCS_W-1:0] crc,
    input logic             din,
    input logic [FCS_W-1:0] poly
  );
    logic fb;
    fb = crc[0] ^ din;
    fcs_step = {1'b0, crc[FCS_W-1:1]} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/hdlc_fcs_acc.sv
module hdlc_fcs_acc
  import hdlc_tx_pkg::*;
#(
  parameter logic [FCS_W-1:0] POLY = 16'h8408,
  parameter logic [FCS_W-1:0] INIT = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             din,
  output logic [FCS_W-1:0] crc_next
);
  logic [FCS_W-1:0] crc_q;

  // Value including the bit being stepped this cycle.
  assign crc_next = step ? fcs_step(crc_q, din, POLY) : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= INIT;
    else if (clear) crc_q <= INIT;
    else if (step)  crc_q <= crc_next;
  end
endmodule

// File: rtl/hdlc_zero_stuff.sv
module hdlc_zero_stuff #(
  parameter int RUN_MAX = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic emit,
  input  logic bit_val,
  input  logic countable,
  output logic stuff_now
);
  localparam int CNT_W = $clog2(RUN_MAX + 1);

  logic [CNT_W-1:0] ones_q;

  assign stuff_now = (ones_q == CNT_W'(RUN_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (bit_en && stuff_now) begin
      ones_q <= '0;
    end else if (emit) begin
      ones_q <= (countable && bit_val) ? ones_q + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int                RUN_MAX  = 5,
  parameter logic [BYTE_W-1:0] FLAG_PAT = 8'h7E,
  parameter logic [FCS_W-1:0]  FCS_POLY = 16'h8408,
  parameter logic [FCS_W-1:0]  FCS_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              tx_bit,
  output logic              underrun_err
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

  seg_e              seg_q;
  logic [BYTE_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              cur_last_q;
  logic [BYTE_W-1:0] fcs_hi_q;

  // Named internal events
  logic              stuff_now;
  logic              tick_stuff;
  logic              tick_emit;
  logic              byte_end;
  logic              need_payload;
  logic              underrun_evt;
  logic              crc_clear;
  logic              crc_step;
  logic [FCS_W-1:0]  crc_next;
  logic [FCS_W-1:0]  fcs_word;

  assign tick_stuff   = bit_en && stuff_now;
  assign tick_emit    = bit_en && !stuff_now;
  assign byte_end     = tick_emit && (idx_q == IDX_LAST);
  assign need_payload = byte_end &&
                        ((seg_q == SEG_FLAG) || (seg_q == SEG_DATA && !cur_last_q));
  assign in_ready     = need_payload && in_valid;
  assign underrun_evt = byte_end && (seg_q == SEG_DATA) && !cur_last_q && !in_valid;
  assign crc_clear    = in_ready && (seg_q == SEG_FLAG);
  assign crc_step     = tick_emit && (seg_q == SEG_DATA);
  assign fcs_word     = ~crc_next;

  hdlc_fcs_acc #(.POLY(FCS_POLY), .INIT(FCS_INIT)) u_fcs (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (crc_clear),
    .step     (crc_step),
    .din      (sh_q[0]),
    .crc_next (crc_next)
  );

  hdlc_zero_stuff #(.RUN_MAX(RUN_MAX)) u_stuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .emit      (tick_emit),
    .bit_val   (sh_q[0]),
    .countable (seg_q != SEG_FLAG),
    .stuff_now (stuff_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q        <= SEG_FLAG;
      sh_q         <= FLAG_PAT;
      idx_q        <= '0;
      cur_last_q   <= 1'b0;
      fcs_hi_q     <= '0;
      tx_bit       <= 1'b1;
      underrun_err <= 1'b0;
    end else begin
      underrun_err <= underrun_evt;
      if (tick_stuff) begin
        tx_bit <= 1'b0;
      end else if (tick_emit) begin
        tx_bit <= sh_q[0];
        idx_q  <= idx_q + 1'b1;
        sh_q   <= sh_q >> 1;
        if (idx_q == IDX_LAST) begin
          case (seg_q)
            SEG_FLAG: begin
              if (in_valid) begin
                seg_q      <= SEG_DATA;
                sh_q       <= in_data;
                cur_last_q <= in_last;
              end else begin
                sh_q <= FLAG_PAT;
              end
            end
            SEG_DATA: begin
              if (cur_last_q) begin
                seg_q    <= SEG_FCS_LO;
                sh_q     <= fcs_word[BYTE_W-1:0];
                fcs_hi_q <= fcs_word[FCS_W-1:BYTE_W];
              end else if (in_valid) begin
                sh_q       <= in_data;
                cur_last_q <= in_last;
              end else begin
                seg_q <= SEG_FLAG;
                sh_q  <= FLAG_PAT;
              end
            end
            SEG_FCS_LO: begin
              seg_q <= SEG_FCS_HI;
              sh_q  <= fcs_hi_q;
            end
            default: begin
              seg_q <= SEG_FLAG;
              sh_q  <= FLAG_PAT;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk #(
  parameter int RUN_MAX = 5
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic in_valid,
  input logic in_ready,
  input logic tx_bit,
  input logic underrun_err,
  input logic tick_stuff
);
  logic       tick_d;
  logic [7:0] line_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_d   <= 1'b0;
      line_run <= '0;
    end else begin
      tick_d <= bit_en;
      if (tick_d) line_run <= tx_bit ? line_run + 1'b1 : '0;
    end
  end

  // R6: an inserted bit appears on the line as a zero
  assert_stuff_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_stuff |=> !tx_bit);

  // R6: no line run of ones beyond a flag's six
  assert_line_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_run <= 8'(RUN_MAX + 1));

  // R7: line holds between ticks
  assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  // R8: acceptance only on a tick with data offered
  assert_ready_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (bit_en && in_valid));

  // R9: underrun error is a single-clock pulse
  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_err |=> !underrun_err);
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.RUN_MAX(RUN_MAX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_en       (bit_en),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .tx_bit       (tx_bit),
  .underrun_err (underrun_err),
  .tick_stuff   (tick_stuff)
);

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] FLAG = 8'h7E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       tx_bit;
  logic       underrun_err;

  int checks = 0;
  int errors = 0;
  int bad_ready = 0;
  int bad_hold = 0;

  logic [7:0] frame [0:15];
  logic       exp_bits [0:1023];
  logic       cap [0:1023];
  int         exp_n;
  int         cap_n;
  int         run1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .tx_bit(tx_bit), .underrun_err(underrun_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Non-reflected CRC over bit-reversed bytes, result reflected and inverted.
  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  function automatic logic [15:0] ref_fcs(input int nb);
    logic [15:0] c;
    logic [15:0] r;
    c = 16'hFFFF;
    for (int b = 0; b < nb; b++) begin
      c = c ^ {rev8(frame[b]), 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    for (int i = 0; i < 16; i++) r[i] = c[15-i];
    return ~r;
  endfunction

  task automatic push_bit(input logic b);
    exp_bits[exp_n] = b;
    exp_n++;
  endtask

  task automatic push_stuffed(input logic [7:0] v);
    for (int k = 0; k < 8; k++) begin
      push_bit(v[k]);
      run1 = v[k] ? run1 + 1 : 0;
      if (run1 == 5) begin
        push_bit(1'b0);
        run1 = 0;
      end
    end
  endtask

  task automatic build_expected(input int nb);
    logic [15:0] f;
    exp_n = 0;
    run1 = 0;
    for (int k = 0; k < 8; k++) push_bit(FLAG[k]);
    for (int b = 0; b < nb; b++) push_stuffed(frame[b]);
    f = ref_fcs(nb);
    push_stuffed(f[7:0]);
    push_stuffed(f[15:8]);
    for (int k = 0; k < 8; k++) push_bit(FLAG[k]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_en = 1'b0;
    in_valid = 1'b0;
    in_last = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drives nb bytes (last marked if mark_last) and captures until want bits or max cycles.
  task automatic drive(input int nb, input bit mark_last, input int per,
                       input int want, input int max_cyc, output int taken,
                       output int err_cyc);
    int  bi;
    bit  ten;
    bit  ten_d;
    bit  take;
    logic last_tx;
    bi = 0; ten_d = 0; take = 0; cap_n = 0; err_cyc = 0;
    last_tx = tx_bit;
    for (int cyc = 0; cyc < max_cyc && cap_n < want; cyc++) begin
      @(negedge clk);
      if (ten_d) begin
        cap[cap_n] = tx_bit;
        cap_n++;
      end else if (tx_bit !== last_tx) begin
        bad_hold++;
      end
      last_tx = tx_bit;
      if (underrun_err) err_cyc++;
      if (take) bi++;
      ten = (cyc % per) == 0;
      bit_en = ten;
      in_valid = bi < nb;
      in_data = frame[bi < 16 ? bi : 0];
      in_last = mark_last && (bi == nb - 1);
      #1;
      if (in_ready && !ten) bad_ready++;
      take = in_ready;
      ten_d = ten;
    end
    taken = bi;
  endtask

  task automatic run_frame(input int nb, input int per, input string tag);
    int taken;
    int err_cyc;
    int mism;
    int first;
    logic e;
    do_reset();
    build_expected(nb);
    drive(nb, 1'b1, per, exp_n + 16, (exp_n + 40) * per, taken, err_cyc);
    mism = 0;
    first = -1;
    for (int i = 0; i < exp_n + 16; i++) begin
      e = (i < exp_n) ? exp_bits[i] : FLAG[(i - exp_n) % 8];
      if (i >= cap_n || cap[i] !== e) begin
        mism++;
        if (first < 0) first = i;
      end
    end
    check(mism == 0, {tag, " R3 R4 R5 R6 line stream (first bad index)"}, first, -1);
    check(taken == nb && err_cyc == 0, {tag, " R8 bytes accepted"}, taken, nb);
  endtask

  initial begin
    int taken;
    int err_cyc;
    int found;
    logic [15:0] f;

    // R1: reset state
    do_reset();
    #1;
    check(tx_bit === 1'b1 && in_ready === 1'b0 && underrun_err === 1'b0,
          "R1 reset outputs", {tx_bit, in_ready, underrun_err}, 3'b100);

    // R2: idle flags
    drive(0, 1'b0, 1, 32, 200, taken, err_cyc);
    found = 0;
    for (int i = 0; i < 32; i++) if (cap[i] !== FLAG[i % 8]) found++;
    check(found == 0 && cap_n == 32, "R2 idle flag stream mismatches", found, 0);

    // R5: bench reference FCS on the standard check string
    for (int i = 0; i < 9; i++) frame[i] = 8'h31 + 8'(i);
    f = ref_fcs(9);
    check(f == 16'h906E, "R5 reference FCS of check string", f, 16'h906E);
    run_frame(9, 3, "ascii");

    // R3 R4 R6: all one-byte frames
    for (int v = 0; v < 256; v++) begin
      frame[0] = 8'(v);
      run_frame(1, 1, "byte sweep");
    end

    // R4: two-byte frame with 0x11
    frame[0] = 8'hFF; frame[1] = 8'h11;
    run_frame(2, 1, "ff11 fast");
    run_frame(2, 3, "ff11 slow R7");

    // R6: ones running across byte boundaries
    for (int i = 0; i < 4; i++) frame[i] = 8'hFF;
    run_frame(4, 2, "all ones");

    for (int i = 0; i < 3; i++) frame[i] = 8'h00;
    run_frame(3, 1, "zeros");

    frame[0] = FLAG; frame[1] = FLAG;
    run_frame(2, 1, "flag bytes");

    // R9: underrun drops the frame
    do_reset();
    frame[0] = 8'hA5;
    drive(1, 1'b0, 1, 64, 200, taken, err_cyc);
    check(err_cyc == 1, "R9 underrun pulse cycles", err_cyc, 1);
    found = 0;
    for (int i = 0; i < 8; i++) begin
      if (cap[i] !== FLAG[i]) found++;
      if (cap[8+i] !== frame[0][i]) found++;
    end
    check(found == 0, "R4 R9 bits before underrun", found, 0);
    found = 0;
    for (int o = 0; o < 8; o++) begin
      int ok;
      ok = 1;
      for (int k = 0; k < 8; k++) if (cap[cap_n - 16 + o + k] !== FLAG[k]) ok = 0;
      if (ok == 1) found = 1;
    end
    check(found == 1, "R9 flags resume after underrun", found, 1);

    check(bad_ready == 0, "R8 ready without tick", bad_ready, 0);
    check(bad_hold == 0, "R7 line change between ticks", bad_hold, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule